// File: doc/BRIEF.md
# Warp Memory Request Splitter

This block accepts one warp-wide load or store: a vector of 32 lane byte addresses, a mask of active lanes and an element-size code. It cuts the warp into lane groups small enough that the group's data fits in one memory transaction of at most 128 bytes. It then issues those groups one at a time on a valid/ready port.

For elements of four bytes or less, the whole warp is a single group. Eight-byte elements give two half-warp groups of 16 lanes. Sixteen-byte elements give four groups of 8 lanes. Each issued transaction carries its first lane index, its group width and the active-lane mask restricted to its own lanes. The return path can use these to route data back to the right lanes. Groups with no active lane are never issued.

The block holds one warp at a time. It is ready for a new warp only when idle. It signals completion with a one-cycle pulse.

Top module: `wsplit_top`

## Requirements
- R1: Size code `in_size` gives the element size as 2^code bytes (0=1 B, 1=2 B, 2=4 B, 3=8 B, 4=16 B); codes above 4 behave as 16 B. Codes 0 to 2 produce a single 32-lane group starting at lane 0.
- R2: Code 3 splits the warp into two 16-lane groups: lanes 0-15 and lanes 16-31.
- R3: Codes 4 and above split the warp into four 8-lane groups starting at lanes 0, 8, 16 and 24.
- R4: Groups are issued in ascending lane order. `tx_first_lane` is the group's lowest lane index and `tx_piece_lanes` is its width.
- R5: `tx_lane_mask` bit i equals the captured active bit of lane i for lanes inside the issued group, and is 0 for every other lane.
- R6: A group with no active lane is skipped. A warp whose mask is all zero issues no transaction but still completes.
- R7: While `tx_valid` is high and `tx_ready` is low, every transaction output holds its value.
- R8: `done` is high for exactly one cycle, in the cycle after the last group is accepted, or in the cycle after the busy cycle of an all-inactive warp.
- R9: `in_ready` is high only when no warp is held. `in_valid` while busy has no effect on the warp being issued.
- R10: After reset, `in_ready` is 1, and `tx_valid` and `done` are 0.
- R11: Group width times element size never exceeds 128 bytes.
- R12: `tx_addr` carries the 32 lane addresses captured with the warp, with lane i in bits [32*i+31:32*i], and `tx_size` echoes the captured size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Warp request present |
| in_ready | output | 1 | Block idle and able to take a warp |
| in_size | input | 3 | Element size code, log2 of bytes |
| in_mask | input | 32 | Active lane mask |
| in_addr | input | 1024 | Lane addresses, 32 bits per lane |
| tx_valid | output | 1 | Transaction present |
| tx_ready | input | 1 | Downstream accepts the transaction |
| tx_size | output | 3 | Captured size code |
| tx_first_lane | output | 5 | Lowest lane of the group |
| tx_piece_lanes | output | 6 | Lanes in the group |
| tx_lane_mask | output | 32 | Active lanes of the group |
| tx_addr | output | 1024 | Captured lane addresses |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the issued transaction stays stable under backpressure;
- its mask never strays outside its own lane window and is never empty;
- its byte count stays within 128;
- the block never issues while idle;
- `done` never lasts two cycles.

The following can only be shown by the bench's sweep over size codes and mask patterns, with and without stalls:
- that the right groups appear, in ascending order;
- that empty groups are skipped;
- that completion arrives on the correct cycle;
- that a request offered while busy leaves the current warp intact.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} wsplit_state_e;

  // log2 of group width for a size code, clamped to the lane count
  function automatic int piece_log(int size_code, int lane_log, int tx_log, int max_sz);
    int szc;
    int p;
    szc = (size_code > max_sz) ? max_sz : size_code;
    p = tx_log - szc;
    if (p > lane_log) p = lane_log;
    if (p < 0) p = 0;
    return p;
  endfunction
endpackage

// File: rtl/wsplit_geom.sv
module wsplit_geom #(
  parameter int LANES    = 32,
  parameter int TX_BYTES = 128,
  parameter int MAX_SZ   = 4,
  parameter int SIZE_W   = 3,
  parameter int PW_W     = 3,
  parameter int IDX_W    = 3,
  parameter int LW       = 6
) (
  input  logic [SIZE_W-1:0] size,
  output logic [PW_W-1:0]   pw,
  output logic [IDX_W-1:0]  npieces,
  output logic [LW-1:0]     plen
);
  localparam int LANE_LOG = $clog2(LANES);
  localparam int TX_LOG   = $clog2(TX_BYTES);

  int p_log;

  always_comb begin
    p_log   = wsplit_pkg::piece_log(int'(size), LANE_LOG, TX_LOG, MAX_SZ);
    pw      = PW_W'(p_log);
    plen    = LW'(1 << p_log);
    npieces = IDX_W'(LANES >> p_log);
  end
endmodule

// File: rtl/wsplit_scan.sv
module wsplit_scan #(
  parameter int LANES = 32,
  parameter int MAXP  = 4,
  parameter int IDX_W = 3,
  parameter int LW    = 6
) (
  input  logic [LANES-1:0] mask,
  input  logic [LW-1:0]    plen,
  input  logic [IDX_W-1:0] npieces,
  input  logic [IDX_W-1:0] cur,
  output logic             found,
  output logic [IDX_W-1:0] fidx,
  output logic             last,
  output logic [LANES-1:0] pmask
);
  logic [LANES-1:0] low_win;
  logic [MAXP-1:0]  nonempty;
  logic [MAXP-1:0]  remain;
  int               rem_cnt;

  always_comb begin
    low_win = (LANES'(1) << plen) - LANES'(1);
    for (int j = 0; j < MAXP; j++) begin
      nonempty[j] = (j < int'(npieces)) && (|(mask & (low_win << (j * int'(plen)))));
      remain[j]   = nonempty[j] && (j >= int'(cur));
    end
  end

  always_comb begin
    found   = 1'b0;
    fidx    = '0;
    rem_cnt = 0;
    for (int j = MAXP - 1; j >= 0; j--) begin
      if (remain[j]) begin
        found = 1'b1;
        fidx  = IDX_W'(j);
        rem_cnt = rem_cnt + 1;
      end
    end
    last  = (rem_cnt == 1);
    pmask = mask & (low_win << (int'(fidx) * int'(plen)));
  end
endmodule

// File: rtl/wsplit_top.sv
module wsplit_top #(
  parameter int LANES    = 32,
  parameter int AW       = 32,
  parameter int TX_BYTES = 128,
  parameter int MAX_SZ   = 4,
  parameter int SIZE_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SIZE_W-1:0]     in_size,
  input  logic [LANES-1:0]      in_mask,
  input  logic [LANES*AW-1:0]   in_addr,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [SIZE_W-1:0]     tx_size,
  output logic [$clog2(LANES)-1:0] tx_first_lane,
  output logic [$clog2(LANES):0]   tx_piece_lanes,
  output logic [LANES-1:0]      tx_lane_mask,
  output logic [LANES*AW-1:0]   tx_addr,
  output logic                  done
);
  import wsplit_pkg::*;

  localparam int LANE_LOG = $clog2(LANES);
  localparam int TX_LOG   = $clog2(TX_BYTES);
  localparam int MIN_PW   = piece_log(MAX_SZ, LANE_LOG, TX_LOG, MAX_SZ);
  localparam int MAXP     = LANES >> MIN_PW;
  localparam int IDX_W    = $clog2(MAXP + 1);
  localparam int PW_W     = $clog2(LANE_LOG + 1);
  localparam int LW       = LANE_LOG + 1;

  // reset synchroniser: asynchronous assertion, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  wsplit_state_e          state_q, state_d;
  logic [LANES-1:0]       mask_q;
  logic [LANES*AW-1:0]    addr_q;
  logic [SIZE_W-1:0]      size_q;
  logic [IDX_W-1:0]       cur_q, cur_d;
  logic                   done_q, done_d;
  logic                   cap_en;

  logic [PW_W-1:0]        pw;
  logic [IDX_W-1:0]       npieces;
  logic [LW-1:0]          plen;
  logic                   found, last;
  logic [IDX_W-1:0]       fidx;
  logic [LANES-1:0]       pmask;

  wsplit_geom #(
    .LANES(LANES), .TX_BYTES(TX_BYTES), .MAX_SZ(MAX_SZ), .SIZE_W(SIZE_W),
    .PW_W(PW_W), .IDX_W(IDX_W), .LW(LW)
  ) geom_i (
    .size(size_q), .pw(pw), .npieces(npieces), .plen(plen)
  );

  wsplit_scan #(
    .LANES(LANES), .MAXP(MAXP), .IDX_W(IDX_W), .LW(LW)
  ) scan_i (
    .mask(mask_q), .plen(plen), .npieces(npieces), .cur(cur_q),
    .found(found), .fidx(fidx), .last(last), .pmask(pmask)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    done_d  = 1'b0;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          cap_en  = 1'b1;
          cur_d   = '0;
          state_d = ST_BUSY;
        end
      end
      default: begin
        if (!found) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (tx_ready) begin
          cur_d = fidx + IDX_W'(1);
          if (last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      done_q  <= done_d;
    end
  end

  // captured warp, written only under the capture enable
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      mask_q <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else if (cap_en) begin
      mask_q <= in_mask;
      addr_q <= in_addr;
      size_q <= in_size;
    end
  end

  assign in_ready       = (state_q == ST_IDLE);
  assign tx_valid       = (state_q == ST_BUSY) && found;
  assign tx_size        = size_q;
  assign tx_first_lane  = LANE_LOG'(int'(fidx) << pw);
  assign tx_piece_lanes = plen;
  assign tx_lane_mask   = pmask;
  assign tx_addr        = addr_q;
  assign done           = done_q;
endmodule

// File: rtl/wsplit_chk.sv
module wsplit_chk #(
  parameter int LANES    = 32,
  parameter int TX_BYTES = 128,
  parameter int MAX_SZ   = 4,
  parameter int SIZE_W   = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_ready,
  input logic                        tx_valid,
  input logic                        tx_ready,
  input logic [SIZE_W-1:0]           tx_size,
  input logic [$clog2(LANES)-1:0]    tx_first_lane,
  input logic [$clog2(LANES):0]      tx_piece_lanes,
  input logic [LANES-1:0]            tx_lane_mask,
  input logic                        done
);
  logic [LANES-1:0] win;
  int               szc;
  always_comb begin
    win = ((LANES'(1) << tx_piece_lanes) - LANES'(1)) << tx_first_lane;
    szc = (int'(tx_size) > MAX_SZ) ? MAX_SZ : int'(tx_size);
  end

  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_lane_mask) &&
      $stable(tx_first_lane) && $stable(tx_piece_lanes)));

  assert_mask_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_lane_mask & ~win) == '0));

  assert_no_empty_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_lane_mask != '0));

  assert_byte_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((int'(tx_piece_lanes) << szc) <= TX_BYTES));

  assert_idle_no_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tx_valid);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind wsplit_top wsplit_chk #(
  .LANES(LANES), .TX_BYTES(TX_BYTES), .MAX_SZ(MAX_SZ), .SIZE_W(SIZE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_size(tx_size), .tx_first_lane(tx_first_lane),
  .tx_piece_lanes(tx_piece_lanes), .tx_lane_mask(tx_lane_mask), .done(done)
);

// File: tb/wsplit_top_tb_top.sv
module wsplit_top_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic                in_ready;
  logic [2:0]          in_size;
  logic [LANES-1:0]    in_mask;
  logic [LANES*AW-1:0] in_addr;
  logic                tx_valid;
  logic                tx_ready;
  logic [2:0]          tx_size;
  logic [4:0]          tx_first_lane;
  logic [5:0]          tx_piece_lanes;
  logic [LANES-1:0]    tx_lane_mask;
  logic [LANES*AW-1:0] tx_addr;
  logic                done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wsplit_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_size(in_size), .in_mask(in_mask), .in_addr(in_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_size(tx_size),
    .tx_first_lane(tx_first_lane), .tx_piece_lanes(tx_piece_lanes),
    .tx_lane_mask(tx_lane_mask), .tx_addr(tx_addr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LANES*AW-1:0] make_addr(input int base, input int bytes);
    logic [LANES*AW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*AW +: AW] = AW'(base + i * bytes);
    return v;
  endfunction

  // one warp: drive, then follow every expected group; stall selects backpressure
  task automatic run_warp(input int sz, input logic [LANES-1:0] m, input int base,
                          input bit stall, input bit poke_busy);
    int b, w, np, issued;
    logic [LANES-1:0] slice;
    logic [LANES*AW-1:0] av;
    b  = (sz > 4) ? 4 : sz;
    w  = ((128 >> b) > LANES) ? LANES : (128 >> b);
    np = LANES / w;
    av = make_addr(base, 1 << b);
    @(negedge clk);
    chk(in_ready === 1'b1, "R9 idle ready", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_size = 3'(sz); in_mask = m; in_addr = av;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready === 1'b0, "R9 busy not ready", 64'(in_ready), 64'd0);
    issued = 0;
    for (int j = 0; j < np; j++) begin
      slice = m & (((LANES'(1) << w) - LANES'(1)) << (j * w));
      if (slice != '0) begin
        if (stall && (issued % 2 == 0)) begin
          tx_ready = 1'b0;
          if (poke_busy) begin
            in_valid = 1'b1; in_mask = ~m; in_size = 3'd0; in_addr = '1;
          end
          @(negedge clk);
          in_valid = 1'b0;
          chk(tx_valid === 1'b1, "R7 held valid", 64'(tx_valid), 64'd1);
        end
        tx_ready = 1'b1;
        chk(tx_valid === 1'b1, "R4 valid", 64'(tx_valid), 64'd1);
        chk(int'(tx_first_lane) == j * w, "R4 R2 R3 first lane", 64'(tx_first_lane), 64'(j * w));
        chk(int'(tx_piece_lanes) == w, "R1 R2 R3 group width", 64'(tx_piece_lanes), 64'(w));
        chk(tx_lane_mask === slice, "R5 R6 lane mask", 64'(tx_lane_mask), 64'(slice));
        chk(tx_addr === av, "R12 R9 addresses", 64'(tx_addr[AW-1:0]), 64'(av[AW-1:0]));
        chk(int'(tx_size) == sz, "R12 size echo", 64'(tx_size), 64'(sz));
        chk(int'(tx_piece_lanes) * (1 << b) <= 128, "R11 byte limit",
            64'(int'(tx_piece_lanes) * (1 << b)), 64'd128);
        chk(done === 1'b0, "R8 no early done", 64'(done), 64'd0);
        issued++;
        @(negedge clk);
      end
    end
    if (issued == 0) begin
      chk(tx_valid === 1'b0, "R6 empty warp no issue", 64'(tx_valid), 64'd0);
      @(negedge clk);
    end
    chk(done === 1'b1, "R8 done pulse", 64'(done), 64'd1);
    chk(tx_valid === 1'b0, "R6 nothing after last", 64'(tx_valid), 64'd0);
    chk(in_ready === 1'b1, "R9 ready after done", 64'(in_ready), 64'd1);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LANES-1:0] pats [8];
    logic [LANES-1:0] lf;
    rst_n = 1'b0; in_valid = 1'b0; in_size = '0; in_mask = '0; in_addr = '0; tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R10 reset ready", 64'(in_ready), 64'd1);
    chk(tx_valid === 1'b0, "R10 reset valid", 64'(tx_valid), 64'd0);
    chk(done === 1'b0, "R10 reset done", 64'(done), 64'd0);

    pats[0] = '1;
    pats[1] = '0;
    pats[2] = 32'h0000_0001;
    pats[3] = 32'h8000_0000;
    pats[4] = 32'h0000_FFFF;
    pats[5] = 32'hFF00_00FF;
    pats[6] = 32'h00F0_0000;
    pats[7] = 32'h5555_AAAA;
    for (int sz = 0; sz < 8; sz++)
      for (int p = 0; p < 8; p++)
        run_warp(sz, pats[p], 32'h1000 * (p + 1), (p % 2) == 1, 1'b0);

    lf = 32'hACE1_2345;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_warp(k % 6, lf & {LANES{(k % 7) != 3}}, 32'h40 * k, k[0], 1'b1);
    end
    for (int sz = 3; sz < 5; sz++) run_warp(sz, 32'hFFFF_FFFF, 32'h2000, 1'b1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule